// File: doc/BRIEF.md
# Sampled counter slip validator

This block watches several external timing references. Each reference drives a free-running counter in its own clock domain. The local clock domain samples those counters on a sample strobe, and the block decides whether a reference has slipped. An asynchronous capture can resolve to a wrong count. A single reading is therefore never trusted. Each counter value first passes through a chain of resynchronizing flops.

A single shared checker then serves the references one at a time, in a fixed rotation. For the reference it is serving, the checker collects a group of consecutive strobed readings. A group whose readings are all identical is accepted, and its value is reported together with the reference number. A group containing any disagreement is thrown away whole. The checker then collects a fresh group from the same reference, and the rejection is counted.

Each reference keeps its own last accepted value. The first accepted value after reset only sets that baseline. After that, a slip is flagged whenever a newly accepted value differs from the stored one.

Top module: `slip_validator`

## Requirements
- R1: While reset is asserted and after it is released, `res_valid` and `res_slip` are 0 and `discard_count` is 0 until the first group completes.
- R2: Every counter lane passes through three resynchronizing flop stages. A strobe samples the value the lane carried three clock edges earlier, so a change applied in the same cycle as the strobe is not seen by it.
- R3: A group is five strobed samples. `res_valid` pulses for exactly one cycle, in the cycle after the clock edge that takes the fifth sample. It stays 0 after the first four samples.
- R4: If all five samples of a group are equal, the group is accepted. `res_value` then carries the sampled value and `res_lane` carries the reference number (0-based lane index, lane k occupying bits k*8+7..k*8 of `ref_counts`).
- R5: If any sample in a group differs from the others, no result is produced. `discard_count` rises by one, and the next group is taken from the same reference.
- R6: After an accepted group the checker moves to the next reference: 0, 1, 2, 3, 4, then back to 0. Rejected groups do not move it.
- R7: The first accepted group of each reference after reset is a baseline and never raises `res_slip`.
- R8: `res_slip` pulses together with `res_valid` when the accepted value differs from the previous accepted value of that same reference, and stays 0 when they are equal.
- R9: `discard_count` saturates at its maximum (15 for the default 4-bit width) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | Take one sample of the current reference this cycle |
| ref_counts | input | NUM_REFS*CNT_W (40) | Asynchronous counter values, one lane per reference |
| res_value | output | CNT_W (8) | Accepted counter value |
| res_lane | output | LANE_W (3) | Reference number of the accepted value |
| res_valid | output | 1 | One-cycle pulse marking an accepted group |
| res_slip | output | 1 | Accepted value moved from the reference's previous accepted value |
| discard_count | output | DISC_W (4) | Saturating count of rejected groups |

## Verification
A counter value applied to a lane becomes visible to a strobe three edges later. The bench therefore changes lane values on a falling edge and holds them for three falling edges before raising the strobe. One test deliberately strobes in the same cycle as a change to show that the old value is used.

The verdict of a group is due one cycle after the edge that takes the fifth sample. The bench reads `res_valid`, `res_value`, `res_lane`, `res_slip` and `discard_count` on the falling edge right after that sampling edge. It confirms one falling edge later that the pulse has dropped, and it checks that no result appears after the first four samples.

// File: rtl/slipval_pkg.sv
package slipval_pkg;

  // Next reference in the rotation, wrapping at n.
  function automatic int unsigned next_lane(input int unsigned cur, input int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

  // Saturating increment on an integer with a given maximum.
  function automatic int unsigned sat_step(input int unsigned cur, input int unsigned max_v);
    return (cur >= max_v) ? max_v : cur + 1;
  endfunction

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int W      = 8,
  parameter int STAGES = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/group_checker.sv
module group_checker #(
  parameter int W   = 8,
  parameter int LEN = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic [W-1:0] din,
  output logic         close_o,
  output logic         agree_o,
  output logic [W-1:0] head_o
);

  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  first_q;
  logic          mis_q;
  logic          at_start;
  logic          at_last;

  assign at_start = (cnt_q == '0);
  assign at_last  = (cnt_q == LAST);
  assign head_o   = at_start ? din : first_q;
  assign close_o  = stb && at_last;
  assign agree_o  = (at_start || !mis_q) && (din == head_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      first_q <= '0;
      mis_q   <= 1'b0;
    end else if (stb) begin
      cnt_q <= at_last ? '0 : cnt_q + 1'b1;
      if (at_start) begin
        first_q <= din;
        mis_q   <= 1'b0;
      end else begin
        mis_q <= mis_q | (din != first_q);
      end
    end
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(cnt_q));

endmodule

// File: rtl/baseline_tracker.sv
module baseline_tracker #(
  parameter int W  = 8,
  parameter int N  = 5,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [LW-1:0] lane,
  input  logic [W-1:0]  val,
  output logic          valid_o,
  output logic [W-1:0]  value_o,
  output logic [LW-1:0] lane_o,
  output logic          slip_o
);

  logic [W-1:0] base_q [N];
  logic [N-1:0] have_q;
  logic         moved;

  assign moved = have_q[lane] && (base_q[lane] != val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      slip_o  <= 1'b0;
      value_o <= '0;
      lane_o  <= '0;
      have_q  <= '0;
      for (int i = 0; i < N; i++) base_q[i] <= '0;
    end else begin
      valid_o <= accept;
      slip_o  <= accept && moved;
      if (accept) begin
        value_o      <= val;
        lane_o       <= lane;
        base_q[lane] <= val;
        have_q[lane] <= 1'b1;
      end
    end
  end

  // R7
  first_no_slip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !have_q[lane]) |=> !slip_o);

  // R8
  slip_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slip_o |-> valid_o);

endmodule

// File: rtl/slip_validator.sv
module slip_validator
  import slipval_pkg::*;
#(
  parameter int NUM_REFS    = 5,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 3,
  parameter int GROUP_LEN   = 5,
  parameter int DISC_W      = 4,
  parameter int LANE_W      = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sample_stb,
  input  logic [NUM_REFS*CNT_W-1:0] ref_counts,
  output logic [CNT_W-1:0]          res_value,
  output logic [LANE_W-1:0]         res_lane,
  output logic                      res_valid,
  output logic                      res_slip,
  output logic [DISC_W-1:0]         discard_count
);

  localparam int unsigned DISC_MAX = (1 << DISC_W) - 1;

  logic [CNT_W-1:0]  synced [NUM_REFS];
  logic [LANE_W-1:0] ptr_q;
  logic [CNT_W-1:0]  cur_val;
  logic              grp_close;
  logic              grp_agree;
  logic [CNT_W-1:0]  grp_head;
  logic              accept_evt;
  logic              reject_evt;

  generate
    for (genvar l = 0; l < NUM_REFS; l++) begin : g_lane
      sync_chain #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ref_counts[l*CNT_W +: CNT_W]),
        .q     (synced[l])
      );
    end
  endgenerate

  assign cur_val = synced[ptr_q];

  group_checker #(.W(CNT_W), .LEN(GROUP_LEN)) u_group (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (sample_stb),
    .din     (cur_val),
    .close_o (grp_close),
    .agree_o (grp_agree),
    .head_o  (grp_head)
  );

  assign accept_evt = grp_close && grp_agree;
  assign reject_evt = grp_close && !grp_agree;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q         <= '0;
      discard_count <= '0;
    end else begin
      if (accept_evt)
        ptr_q <= LANE_W'(next_lane(int'(ptr_q), NUM_REFS));
      if (reject_evt)
        discard_count <= DISC_W'(sat_step(int'(discard_count), DISC_MAX));
    end
  end

  baseline_tracker #(.W(CNT_W), .N(NUM_REFS), .LW(LANE_W)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept_evt),
    .lane    (ptr_q),
    .val     (grp_head),
    .valid_o (res_valid),
    .value_o (res_value),
    .lane_o  (res_lane),
    .slip_o  (res_slip)
  );

  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R3
  valid_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(sample_stb));

  // R5
  accept_no_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $stable(discard_count));

  // R6
  rotation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q != $past(ptr_q)) |-> (ptr_q == LANE_W'(next_lane(int'($past(ptr_q)), NUM_REFS))));

  // R9
  discard_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(discard_count) == DISC_W'(DISC_MAX)) |-> (discard_count == DISC_W'(DISC_MAX)));

endmodule

// File: tb/slip_validator_test.sv
module slip_validator_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_stb = 1'b0;
  logic [39:0] ref_counts = '0;
  logic [7:0]  res_value;
  logic [2:0]  res_lane;
  logic        res_valid;
  logic        res_slip;
  logic [3:0]  discard_count;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  slip_validator uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .sample_stb    (sample_stb),
    .ref_counts    (ref_counts),
    .res_value     (res_value),
    .res_lane      (res_lane),
    .res_valid     (res_valid),
    .res_slip      (res_slip),
    .discard_count (discard_count)
  );

  // Five samples per group, first sample in the top byte.
  localparam int NV = 10;
  localparam logic [39:0] SAMP [NV] = '{
    40'h0a0a0a0a0a, 40'h1414151414, 40'h1414141414, 40'h1e1e1e1e1e,
    40'h2828282828, 40'h3232323232, 40'h0a0a0a0a0a, 40'h1616161616,
    40'h1e1e1e1e1f, 40'h1f1f1f1f1f };
  // {accepted, slip, lane}
  localparam logic [4:0] EXPV [NV] = '{
    {1'b1,1'b0,3'd0}, {1'b0,1'b0,3'd1}, {1'b1,1'b0,3'd1}, {1'b1,1'b0,3'd2},
    {1'b1,1'b0,3'd3}, {1'b1,1'b0,3'd4}, {1'b1,1'b0,3'd0}, {1'b1,1'b1,3'd1},
    {1'b0,1'b0,3'd2}, {1'b1,1'b1,3'd2} };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_lane(input int lane, input logic [7:0] v);
    for (int l = 0; l < 5; l++) ref_counts[l*8 +: 8] = v ^ 8'hA5 ^ 8'(l);
    ref_counts[lane*8 +: 8] = v;
  endtask

  task automatic one_sample(input int lane, input logic [7:0] v);
    @(negedge clk);
    set_lane(lane, v);
    repeat (3) @(negedge clk);
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
  endtask

  task automatic run_group(input int lane, input logic [39:0] s, input bit ok,
                           input bit slip, input string tag);
    for (int i = 0; i < 5; i++) begin
      one_sample(lane, s[39-8*i -: 8]);
      if (i < 4) chk({tag, " R3 no result mid-group"}, 32'(res_valid), 32'd0);
    end
    chk({tag, " R4/R5 verdict"}, 32'(res_valid), 32'(ok));
    if (ok) begin
      chk({tag, " R4 value"}, 32'(res_value), 32'(s[39:32]));
      chk({tag, " R6 lane"}, 32'(res_lane), 32'(lane));
      chk({tag, " R7/R8 slip"}, 32'(res_slip), 32'(slip));
    end
    @(negedge clk);
    chk({tag, " R3 single pulse"}, 32'(res_valid), 32'd0);
  endtask

  initial begin
    set_lane(0, 8'h00);
    repeat (4) @(negedge clk);
    // R1: outputs during reset
    chk("R1 valid in reset", 32'(res_valid), 32'd0);
    chk("R1 discard in reset", 32'(discard_count), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 slip after reset", 32'(res_slip), 32'd0);
    chk("R1 valid after reset", 32'(res_valid), 32'd0);

    for (int v = 0; v < NV; v++)
      run_group(int'(EXPV[v][2:0]), SAMP[v], EXPV[v][4], EXPV[v][3], $sformatf("vec%0d", v));
    // R5: two groups were thrown away
    chk("R5 discard count", 32'(discard_count), 32'd2);

    // R2: change applied in the strobe cycle is not seen; lane 3 is current
    for (int i = 0; i < 4; i++) one_sample(3, 8'h28);
    @(negedge clk);
    set_lane(3, 8'h41);
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    chk("R2 accepted despite late change", 32'(res_valid), 32'd1);
    chk("R2 old value used", 32'(res_value), 32'h28);
    chk("R2 no slip vs baseline", 32'(res_slip), 32'd0);

    // R9: saturation on lane 4
    for (int g = 0; g < 13; g++) run_group(4, 40'h0101010102, 1'b0, 1'b0, "R9 fill");
    chk("R9 reached max", 32'(discard_count), 32'd15);
    run_group(4, 40'h0303030304, 1'b0, 1'b0, "R9 extra");
    chk("R9 holds max", 32'(discard_count), 32'd15);
    // R6: still on lane 4 after rejections; accept then wrap to 0
    run_group(4, 40'h3232323232, 1'b1, 1'b0, "R6 lane4");
    run_group(0, 40'h0b0b0b0b0b, 1'b1, 1'b1, "R6 wrap lane0");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule